// File: doc/BRIEF.md
# Critical Uplink Command Decoder

This block sits between the spacecraft's uplink command receiver and two consumers: the on-board processor and the relay power-switching unit. Each 16-bit command word is classified on arrival. Ordinary words are handed to the processor through a one-entry slot with a valid/ready handshake. Relay commands marked critical go straight to the relay output without involving the processor. Words addressed to the decoder itself are executed locally. The processor may also send its own relay commands. Each of those is acknowledged with a one-cycle pulse once the relay unit has taken it.

Two autonomous functions protect the spacecraft. An inactivity watchdog is restarted by every uplink word. If it runs out, the block raises a timeout event and applies a fixed-length reset to itself and to the receiver. A rising edge on the hard low-voltage flag starts a stored load-shed sequence. The sequence is a parameter table of relay numbers, issued in table order with a programmable gap between entries, and the processor is notified when it starts. The relay output carries one command at a time. Critical commands win over the load-shed sequence, which wins over processor requests.

The command word layout is as follows. Bit 15 is the critical mark. Bits 14:12 are the destination: 0 is the processor, 1 is a relay, 2 is local, and any other value is treated as the processor. Bits 11:0 are the payload or relay number. For local words, payload bits 11:8 are the opcode.

The block contains four state machines:
- Watchdog: states WD_RUN and WD_HOLD. WD_RUN goes to WD_HOLD on expiry. WD_HOLD goes back to WD_RUN after HOLD_CYCLES.
- Load-shed sequencer: states SH_IDLE, SH_REQ and SH_GAP. SH_IDLE goes to SH_REQ on a start. SH_REQ goes to SH_GAP when an entry is granted, or to SH_IDLE after the last entry or on abort. SH_GAP goes back to SH_REQ when the gap has elapsed, or to SH_IDLE on abort.
- Relay arbiter: states AR_IDLE and AR_SEND. AR_IDLE goes to AR_SEND on any grant. AR_SEND goes back to AR_IDLE on the handshake.
- Internal reset: forces every machine to its idle state.

Top module: `crit_uplink_decoder`

## Requirements
- R1: A live uplink word is routed to the processor slot (`pfw_valid`/`pfw_word`, full 16 bits) when it is neither local (bits 14:12 = 2) nor critical relay (bit 15 = 1 with bits 14:12 = 1). The word is visible the cycle after it arrives. It stays stable until `pfw_ready`, and a word that arrives while the slot is full and not draining is dropped.
- R2: A critical relay word never reaches the processor slot. Its bits 11:0 appear on `rly_num` with `rly_valid` two cycles after arrival, provided the arbiter is idle.
- R3: `prq_ready` is high for one cycle when a processor relay request is accepted. `prq_sent` pulses for one cycle, the cycle after the relay handshake of that request.
- R4: The relay output carries one command at a time. `rly_num` stays stable while `rly_valid` is high and `rly_ready` is low.
- R5: When several sources wait on an idle arbiter, the critical command is granted first, then the load-shed entry, then the processor request.
- R6: Every live uplink word restarts the watchdog. WD_CYCLES cycles without one cause a one-cycle `wd_event` and start the internal reset.
- R7: The internal reset holds `rx_rst` high for exactly HOLD_CYCLES (16) cycles. It clears the processor slot, the critical slot, the sequence and the relay output. Uplink words, processor requests and local commands are ignored during it.
- R8: A rising edge of `lowv_flag` in SH_IDLE starts the sequence and pulses `shed_event` the next cycle. A flag held high, or a new edge during an active sequence, starts nothing.
- R9: The sequence issues the SHED_N table entries in order, entry 0 first from the low bits of SHED_TABLE. After each entry is granted, SHED_GAP cycles pass before the next request.
- R10: A local word with opcode 1 starts the sequence as the flag does. Opcode 2 aborts an active sequence. Any other opcode has no effect. Local words are never forwarded.
- R11: After reset, `rx_rst`, `rly_valid`, `pfw_valid`, `prq_sent`, `wd_event` and `shed_event` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Uplink word strobe |
| up_word | input | 16 | Uplink command word |
| lowv_flag | input | 1 | Hard low-voltage flag from the power subsystem |
| pfw_valid | output | 1 | Processor slot holds a word |
| pfw_word | output | 16 | Word forwarded to the processor |
| pfw_ready | input | 1 | Processor takes the slot word |
| prq_valid | input | 1 | Processor relay request |
| prq_num | input | 12 | Processor relay number |
| prq_ready | output | 1 | Processor request accepted |
| prq_sent | output | 1 | Processor relay command issued |
| rly_valid | output | 1 | Relay command valid |
| rly_num | output | 12 | Relay number |
| rly_ready | input | 1 | Relay unit takes the command |
| rx_rst | output | 1 | Reset to the uplink receiver (internal reset active) |
| wd_event | output | 1 | Watchdog timeout event pulse |
| shed_event | output | 1 | Load-shed start event pulse |

## Verification
An uplink word shows in the processor slot one cycle after its strobe. A critical relay word reaches `rly_valid` one cycle later still. An accepted processor request drives the relay output on the next cycle and `prq_sent` on the cycle after its handshake. A low-voltage edge gives `shed_event` on the next cycle and the first load-shed request two cycles later. The timeout fires WD_CYCLES edges after the last word. The bench's behavioural model applies each input at the same rising edge the design does. Inputs change one nanosecond after that edge, and every output is compared against the model at the falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/cud_pkg.sv
package cud_pkg;
    localparam int CMD_W    = 16;
    localparam int DEST_W   = 3;
    localparam int PAY_W    = 12;
    localparam int OPC_W    = 4;
    localparam int CRIT_BIT = 15;
    localparam int DEST_LSB = 12;

    localparam logic [DEST_W-1:0] DST_RELAY = 3'd1;
    localparam logic [DEST_W-1:0] DST_LOCAL = 3'd2;

    localparam logic [OPC_W-1:0] OPC_SHED_GO   = 4'h1;
    localparam logic [OPC_W-1:0] OPC_SHED_STOP = 4'h2;

    typedef enum logic [1:0] {CL_PROC, CL_CRIT, CL_LOCAL} cmd_class_e;
    typedef enum logic [1:0] {SRC_CRIT, SRC_SHED, SRC_PROC} rly_src_e;
    typedef enum logic {WD_RUN, WD_HOLD} wd_state_e;
    typedef enum logic [1:0] {SH_IDLE, SH_REQ, SH_GAP} sh_state_e;
    typedef enum logic {AR_IDLE, AR_SEND} ar_state_e;
endpackage

// File: rtl/cud_watchdog.sv
module cud_watchdog import cud_pkg::*; #(
    parameter int WD_CYCLES   = 2000,
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic hold,
    output logic expire_evt
);
    localparam int CNT_W  = $clog2(WD_CYCLES + 1);
    localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0]  WD_LAST   = CNT_W'(WD_CYCLES - 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYCLES - 1);

    wd_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [HOLD_W-1:0] hcnt_q, hcnt_d;
    logic              evt_q, evt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hcnt_d  = hcnt_q;
        evt_d   = 1'b0;
        unique case (state_q)
            WD_RUN: begin
                if (kick) begin
                    cnt_d = '0;
                end else if (cnt_q == WD_LAST) begin
                    state_d = WD_HOLD;
                    hcnt_d  = '0;
                    evt_d   = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            WD_HOLD: begin
                if (hcnt_q == HOLD_LAST) begin
                    state_d = WD_RUN;
                    cnt_d   = '0;
                end else begin
                    hcnt_d = hcnt_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_RUN;
            cnt_q   <= '0;
            hcnt_q  <= '0;
            evt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hcnt_q  <= hcnt_d;
            evt_q   <= evt_d;
        end
    end

    always_comb begin
        hold       = (state_q == WD_HOLD);
        expire_evt = evt_q;
    end

    // R6: the timeout event marks the first cycle of the internal reset
    assert_evt_starts_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire_evt |-> (hold && !$past(hold)));
    // R6: the internal reset is entered only through a timeout event
    assert_hold_from_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> expire_evt);
endmodule

// File: rtl/cud_cmd_route.sv
module cud_cmd_route import cud_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             up_valid,
    input  logic [CMD_W-1:0] up_word,
    input  logic             pfw_ready,
    input  logic             crit_take,
    output logic             pfw_valid,
    output logic [CMD_W-1:0] pfw_word,
    output logic             crit_valid,
    output logic [PAY_W-1:0] crit_num,
    output logic             loc_go,
    output logic             loc_stop
);
    logic              live;
    logic [DEST_W-1:0] fld_dest;
    logic [OPC_W-1:0]  fld_opc;
    cmd_class_e        cls;

    logic             pfw_v_q, pfw_v_d;
    logic [CMD_W-1:0] pfw_w_q, pfw_w_d;
    logic             crit_v_q, crit_v_d;
    logic [PAY_W-1:0] crit_n_q, crit_n_d;

    always_comb begin
        live     = up_valid && !hold;
        fld_dest = up_word[DEST_LSB +: DEST_W];
        fld_opc  = up_word[PAY_W-1 -: OPC_W];
        if (fld_dest == DST_LOCAL)
            cls = CL_LOCAL;
        else if (up_word[CRIT_BIT] && fld_dest == DST_RELAY)
            cls = CL_CRIT;
        else
            cls = CL_PROC;
    end

    always_comb begin
        pfw_v_d  = pfw_v_q;
        pfw_w_d  = pfw_w_q;
        crit_v_d = crit_v_q;
        crit_n_d = crit_n_q;
        if (pfw_v_q && pfw_ready)
            pfw_v_d = 1'b0;
        if (live && cls == CL_PROC && (!pfw_v_q || pfw_ready)) begin
            pfw_v_d = 1'b1;
            pfw_w_d = up_word;
        end
        if (crit_take)
            crit_v_d = 1'b0;
        if (live && cls == CL_CRIT && (!crit_v_q || crit_take)) begin
            crit_v_d = 1'b1;
            crit_n_d = up_word[PAY_W-1:0];
        end
        if (hold) begin
            pfw_v_d  = 1'b0;
            crit_v_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pfw_v_q  <= 1'b0;
            pfw_w_q  <= '0;
            crit_v_q <= 1'b0;
            crit_n_q <= '0;
        end else begin
            pfw_v_q  <= pfw_v_d;
            pfw_w_q  <= pfw_w_d;
            crit_v_q <= crit_v_d;
            crit_n_q <= crit_n_d;
        end
    end

    always_comb begin
        pfw_valid  = pfw_v_q;
        pfw_word   = pfw_w_q;
        crit_valid = crit_v_q;
        crit_num   = crit_n_q;
        loc_go     = live && cls == CL_LOCAL && fld_opc == OPC_SHED_GO;
        loc_stop   = live && cls == CL_LOCAL && fld_opc == OPC_SHED_STOP;
    end

    // R1: a waiting processor word is neither lost nor altered
    assert_pfw_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pfw_valid && !pfw_ready) |=> (hold || (pfw_valid && $stable(pfw_word))));
    // R2: a critical relay word does not fill the processor slot
    assert_crit_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cls == CL_CRIT && !pfw_valid) |=> !pfw_valid);
    // R10: a local word does not fill the processor slot
    assert_local_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cls == CL_LOCAL && !pfw_valid) |=> !pfw_valid);
endmodule

// File: rtl/cud_shed_seq.sv
module cud_shed_seq import cud_pkg::*; #(
    parameter int SHED_N   = 8,
    parameter int SHED_GAP = 4,
    parameter logic [SHED_N*PAY_W-1:0] SHED_TABLE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             lowv,
    input  logic             loc_go,
    input  logic             loc_stop,
    input  logic             grant,
    output logic             req,
    output logic [PAY_W-1:0] req_num,
    output logic             shed_evt
);
    localparam int IDX_W = (SHED_N > 1) ? $clog2(SHED_N) : 1;
    localparam int GAP_W = $clog2(SHED_GAP + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SHED_N - 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(SHED_GAP - 1);

    sh_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [GAP_W-1:0] gap_q, gap_d;
    logic             evt_q, evt_d;
    logic             lowv_q;
    logic             rise;

    always_comb begin
        rise    = lowv && !lowv_q;
        state_d = state_q;
        idx_d   = idx_q;
        gap_d   = gap_q;
        evt_d   = 1'b0;
        unique case (state_q)
            SH_IDLE: begin
                if (rise || loc_go) begin
                    state_d = SH_REQ;
                    idx_d   = '0;
                    evt_d   = 1'b1;
                end
            end
            SH_REQ: begin
                if (loc_stop) begin
                    state_d = SH_IDLE;
                end else if (grant) begin
                    if (idx_q == IDX_LAST) begin
                        state_d = SH_IDLE;
                    end else begin
                        state_d = SH_GAP;
                        gap_d   = '0;
                    end
                end
            end
            SH_GAP: begin
                if (loc_stop) begin
                    state_d = SH_IDLE;
                end else if (gap_q == GAP_LAST) begin
                    state_d = SH_REQ;
                    idx_d   = idx_q + 1'b1;
                end else begin
                    gap_d = gap_q + 1'b1;
                end
            end
            default: state_d = SH_IDLE;
        endcase
        if (hold) begin
            state_d = SH_IDLE;
            evt_d   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
            idx_q   <= '0;
            gap_q   <= '0;
            evt_q   <= 1'b0;
            lowv_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            gap_q   <= gap_d;
            evt_q   <= evt_d;
            lowv_q  <= lowv;
        end
    end

    always_comb begin
        req      = (state_q == SH_REQ);
        req_num  = SHED_TABLE[idx_q*PAY_W +: PAY_W];
        shed_evt = evt_q;
    end

    // R8: the start event only comes out of an idle sequencer
    assert_evt_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shed_evt |-> (req && !$past(req)));
    // R9: an ungranted entry keeps its relay number
    assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !grant && !hold && !loc_stop) |=> (req && $stable(req_num)));
endmodule

// File: rtl/cud_relay_arb.sv
module cud_relay_arb import cud_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             crit_valid,
    input  logic [PAY_W-1:0] crit_num,
    input  logic             shed_req,
    input  logic [PAY_W-1:0] shed_num,
    input  logic             prq_valid,
    input  logic [PAY_W-1:0] prq_num,
    input  logic             rly_ready,
    output logic             crit_take,
    output logic             shed_grant,
    output logic             prq_ready,
    output logic             rly_valid,
    output logic [PAY_W-1:0] rly_num,
    output logic             prq_sent
);
    ar_state_e        state_q, state_d;
    rly_src_e         src_q, src_d;
    logic [PAY_W-1:0] num_q, num_d;
    logic             sent_q, sent_d;
    logic             idle_ok;

    always_comb begin
        idle_ok    = (state_q == AR_IDLE) && !hold;
        crit_take  = idle_ok && crit_valid;
        shed_grant = idle_ok && !crit_valid && shed_req;
        prq_ready  = idle_ok && !crit_valid && !shed_req && prq_valid;
    end

    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        num_d   = num_q;
        sent_d  = 1'b0;
        unique case (state_q)
            AR_IDLE: begin
                if (crit_take) begin
                    state_d = AR_SEND;
                    src_d   = SRC_CRIT;
                    num_d   = crit_num;
                end else if (shed_grant) begin
                    state_d = AR_SEND;
                    src_d   = SRC_SHED;
                    num_d   = shed_num;
                end else if (prq_ready) begin
                    state_d = AR_SEND;
                    src_d   = SRC_PROC;
                    num_d   = prq_num;
                end
            end
            AR_SEND: begin
                if (rly_ready) begin
                    state_d = AR_IDLE;
                    sent_d  = (src_q == SRC_PROC);
                end
            end
        endcase
        if (hold) begin
            state_d = AR_IDLE;
            sent_d  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AR_IDLE;
            src_q   <= SRC_CRIT;
            num_q   <= '0;
            sent_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
            num_q   <= num_d;
            sent_q  <= sent_d;
        end
    end

    always_comb begin
        rly_valid = (state_q == AR_SEND);
        rly_num   = num_q;
        prq_sent  = sent_q;
    end

    // R4: a command waiting on the relay unit is held unchanged
    assert_rly_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rly_valid && !rly_ready) |=> (hold || (rly_valid && $stable(rly_num))));
    // R3: the sent acknowledge follows a completed relay handshake
    assert_sent_after_hs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prq_sent |-> $past(rly_valid && rly_ready));
    // R5: at most one source is granted per cycle
    assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({crit_take, shed_grant, prq_ready}));
    // R4: no new grant while a command is outstanding
    assert_no_grant_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rly_valid |-> !(crit_take || shed_grant || prq_ready));
endmodule

// File: rtl/crit_uplink_decoder.sv
module crit_uplink_decoder import cud_pkg::*; #(
    parameter int WD_CYCLES   = 2000,
    parameter int HOLD_CYCLES = 16,
    parameter int SHED_N      = 8,
    parameter int SHED_GAP    = 4,
    parameter logic [SHED_N*PAY_W-1:0] SHED_TABLE = {
        12'h0C8, 12'h0B7, 12'h0A6, 12'h095,
        12'h084, 12'h073, 12'h062, 12'h051}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    input  logic [CMD_W-1:0]  up_word,
    input  logic              lowv_flag,
    output logic              pfw_valid,
    output logic [CMD_W-1:0]  pfw_word,
    input  logic              pfw_ready,
    input  logic              prq_valid,
    input  logic [PAY_W-1:0]  prq_num,
    output logic              prq_ready,
    output logic              prq_sent,
    output logic              rly_valid,
    output logic [PAY_W-1:0]  rly_num,
    input  logic              rly_ready,
    output logic              rx_rst,
    output logic              wd_event,
    output logic              shed_event
);
    logic             hold;
    logic             crit_valid, crit_take;
    logic [PAY_W-1:0] crit_num;
    logic             loc_go, loc_stop;
    logic             shed_req, shed_grant;
    logic [PAY_W-1:0] shed_num;

    cud_watchdog #(.WD_CYCLES(WD_CYCLES), .HOLD_CYCLES(HOLD_CYCLES)) u_wd (
        .clk(clk), .rst_n(rst_n), .kick(up_valid),
        .hold(hold), .expire_evt(wd_event)
    );

    cud_cmd_route u_route (
        .clk(clk), .rst_n(rst_n), .hold(hold),
        .up_valid(up_valid), .up_word(up_word),
        .pfw_ready(pfw_ready), .crit_take(crit_take),
        .pfw_valid(pfw_valid), .pfw_word(pfw_word),
        .crit_valid(crit_valid), .crit_num(crit_num),
        .loc_go(loc_go), .loc_stop(loc_stop)
    );

    cud_shed_seq #(.SHED_N(SHED_N), .SHED_GAP(SHED_GAP), .SHED_TABLE(SHED_TABLE)) u_shed (
        .clk(clk), .rst_n(rst_n), .hold(hold), .lowv(lowv_flag),
        .loc_go(loc_go), .loc_stop(loc_stop), .grant(shed_grant),
        .req(shed_req), .req_num(shed_num), .shed_evt(shed_event)
    );

    cud_relay_arb u_arb (
        .clk(clk), .rst_n(rst_n), .hold(hold),
        .crit_valid(crit_valid), .crit_num(crit_num),
        .shed_req(shed_req), .shed_num(shed_num),
        .prq_valid(prq_valid), .prq_num(prq_num),
        .rly_ready(rly_ready),
        .crit_take(crit_take), .shed_grant(shed_grant), .prq_ready(prq_ready),
        .rly_valid(rly_valid), .rly_num(rly_num), .prq_sent(prq_sent)
    );

    assign rx_rst = hold;

    // R7: nothing reaches the processor or relay unit during the internal reset
    assert_quiet_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rst && $past(rx_rst)) |-> (!rly_valid && !pfw_valid && !prq_ready));
endmodule

// File: tb/crit_uplink_decoder_tb.sv
module crit_uplink_decoder_tb_top;
    localparam int WD   = 300;
    localparam int HOLD = 16;
    localparam int NSH  = 8;
    localparam int GAP  = 3;
    localparam logic [95:0] TB_TABLE = {
        12'h3C8, 12'h3B7, 12'h3A6, 12'h395,
        12'h384, 12'h373, 12'h362, 12'h351};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_valid = 1'b0;
    logic [15:0] up_word = '0;
    logic        lowv_flag = 1'b0;
    logic        pfw_valid, prq_ready, prq_sent, rly_valid, rx_rst, wd_event, shed_event;
    logic [15:0] pfw_word;
    logic        pfw_ready, rly_ready;
    logic        prq_valid = 1'b0;
    logic [11:0] prq_num = '0;
    logic [11:0] rly_num;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    string ph = "R11 reset";
    int rmode = 0;
    int pmode = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    crit_uplink_decoder #(.WD_CYCLES(WD), .HOLD_CYCLES(HOLD), .SHED_N(NSH),
                          .SHED_GAP(GAP), .SHED_TABLE(TB_TABLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_word(up_word),
        .lowv_flag(lowv_flag), .pfw_valid(pfw_valid), .pfw_word(pfw_word),
        .pfw_ready(pfw_ready), .prq_valid(prq_valid), .prq_num(prq_num),
        .prq_ready(prq_ready), .prq_sent(prq_sent), .rly_valid(rly_valid),
        .rly_num(rly_num), .rly_ready(rly_ready), .rx_rst(rx_rst),
        .wd_event(wd_event), .shed_event(shed_event)
    );

    // ready patterns: 0 always, 1 two cycles of three, 2 never
    always @(posedge clk) begin
        #1;
        cyc++;
        rly_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? (cyc % 3 != 0) : 1'b0;
        pfw_ready = (pmode == 0) ? 1'b1 : (pmode == 1) ? (cyc % 3 != 0) : 1'b0;
    end
    initial begin rly_ready = 1'b1; pfw_ready = 1'b1; end

    // behavioural reference model
    int m_hold, m_wd, m_shed, m_idx, m_gap;
    bit m_pfw_v, m_crit_v, m_busy, m_src_proc, m_sent, m_wdevt, m_shevt, m_lowv_prev;
    logic [15:0] m_pfw_w;
    logic [11:0] m_crit_n, m_rly_n;
    int m_wd_total = 0;
    bit live, is_loc, is_crit, gc, gs, gp, drain, rise, go, stop;

    function automatic logic [11:0] tbl(int i);
        return TB_TABLE[i*12 +: 12];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hold = 0; m_wd = 0; m_shed = 0; m_idx = 0; m_gap = 0;
            m_pfw_v = 0; m_crit_v = 0; m_busy = 0; m_src_proc = 0; m_sent = 0;
            m_wdevt = 0; m_shevt = 0; m_lowv_prev = 0;
        end else begin
            live    = up_valid && m_hold == 0;
            is_loc  = up_word[14:12] == 3'd2;
            is_crit = up_word[15] && up_word[14:12] == 3'd1;
            gc = m_hold == 0 && !m_busy && m_crit_v;
            gs = m_hold == 0 && !m_busy && !m_crit_v && m_shed == 1;
            gp = m_hold == 0 && !m_busy && !m_crit_v && m_shed != 1 && prq_valid;
            rise = lowv_flag && !m_lowv_prev;
            m_lowv_prev = lowv_flag;
            go   = live && is_loc && up_word[11:8] == 4'h1;
            stop = live && is_loc && up_word[11:8] == 4'h2;
            if (m_hold > 0) begin
                m_hold--;
                if (m_hold == 0) m_wd = 0;
                m_pfw_v = 0; m_crit_v = 0; m_shed = 0; m_busy = 0;
                m_sent = 0; m_wdevt = 0; m_shevt = 0;
            end else begin
                m_wdevt = 0;
                if (up_valid) m_wd = 0;
                else if (m_wd == WD - 1) begin m_hold = HOLD; m_wdevt = 1; m_wd_total++; end
                else m_wd++;
                if (m_busy) begin
                    m_sent = rly_ready && m_src_proc;
                    if (rly_ready) m_busy = 0;
                end else begin
                    m_sent = 0;
                    if (gc) begin m_busy = 1; m_src_proc = 0; m_rly_n = m_crit_n; end
                    else if (gs) begin m_busy = 1; m_src_proc = 0; m_rly_n = tbl(m_idx); end
                    else if (gp) begin m_busy = 1; m_src_proc = 1; m_rly_n = prq_num; end
                end
                drain = m_pfw_v && pfw_ready;
                if (live && !is_loc && !is_crit && (!m_pfw_v || drain)) begin
                    m_pfw_v = 1; m_pfw_w = up_word;
                end else if (drain) m_pfw_v = 0;
                if (live && is_crit && (!m_crit_v || gc)) begin
                    m_crit_v = 1; m_crit_n = up_word[11:0];
                end else if (gc) m_crit_v = 0;
                m_shevt = 0;
                case (m_shed)
                    0: if (rise || go) begin m_shed = 1; m_idx = 0; m_shevt = 1; end
                    1: if (stop) m_shed = 0;
                       else if (gs) begin
                           if (m_idx == NSH - 1) m_shed = 0;
                           else begin m_shed = 2; m_gap = 0; end
                       end
                    default: if (stop) m_shed = 0;
                       else if (m_gap == GAP - 1) begin m_shed = 1; m_idx++; end
                       else m_gap++;
                endcase
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", req, ph, $time, act, exp);
        end
    endtask

    int wd_seen = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1 pfw_valid", pfw_valid, m_pfw_v);
            if (m_pfw_v) chk("R1 pfw_word", pfw_word, m_pfw_w);
            chk("R4 rly_valid", rly_valid, m_busy);
            if (m_busy) chk("R2 R5 R9 rly_num", rly_num, m_rly_n);
            chk("R3 prq_ready", prq_ready,
                m_hold == 0 && !m_busy && !m_crit_v && m_shed != 1 && prq_valid);
            chk("R3 prq_sent", prq_sent, m_sent);
            chk("R7 rx_rst", rx_rst, m_hold > 0);
            chk("R6 wd_event", wd_event, m_wdevt);
            chk("R8 shed_event", shed_event, m_shevt);
            if (wd_event) wd_seen++;
        end
    end

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic send(logic [15:0] w);
        up_valid = 1'b1; up_word = w;
        step(1);
        up_valid = 1'b0;
    endtask

    // keep the watchdog alive with a no-op local word (opcode 0)
    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            if (k % 64 == 63) send(16'h2000); else step(1);
        end
    endtask

    task automatic prq_send(logic [11:0] num);
        bit got;
        got = 1'b0;
        prq_valid = 1'b1; prq_num = num;
        for (int k = 0; k < 200 && !got; k++) begin
            @(negedge clk); got = prq_ready;
            step(1);
        end
        prq_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    initial begin
        int hi;
        step(4);
        rst_n = 1'b1;
        step(1);
        @(negedge clk);
        // R11 reset state
        chk("R11 rx_rst", rx_rst, 0);
        chk("R11 rly_valid", rly_valid, 0);
        chk("R11 pfw_valid", pfw_valid, 0);
        chk("R11 events", {prq_sent, wd_event, shed_event}, 0);
        step(1);

        ph = "R1 processor forward";
        for (int i = 0; i < 5; i++) begin send(16'h0100 + 16'(i)); step(1); end
        send(16'h7ABC); send(16'h4123); step(2);
        pmode = 2; step(1);
        send(16'h0AAA); send(16'h0BBB); send(16'h0CCC); step(3);
        pmode = 1; step(3);
        send(16'h0DDD); send(16'h0EEE); step(4);
        pmode = 0; step(2);

        ph = "R2 critical bypass";
        send(16'h9005); step(4);
        send(16'h1006); step(3);
        send(16'h8007); step(3);
        rmode = 1; send(16'h9ABC); send(16'h9123); step(8);
        rmode = 0; step(2);

        ph = "R3 processor relay";
        prq_send(12'h055); step(3);
        rmode = 1; prq_send(12'h066); prq_send(12'h077); step(6);

        ph = "R5 priority";
        rmode = 2; prq_send(12'h011);
        prq_valid = 1'b1; prq_num = 12'h022;
        send(16'h9033); step(2);
        lowv_flag = 1'b1; step(4);
        rmode = 1; step(20);
        prq_valid = 1'b0; idle(40);
        lowv_flag = 1'b0; rmode = 0; step(2);

        ph = "R8 R9 load shed";
        lowv_flag = 1'b1; idle(12);
        lowv_flag = 1'b0; step(1); lowv_flag = 1'b1;
        idle(60);
        lowv_flag = 1'b0; step(2);
        rmode = 1; lowv_flag = 1'b1; idle(70); lowv_flag = 1'b0; rmode = 0;

        ph = "R10 local commands";
        send(16'h2300); step(5);
        send(16'h2100); idle(9);
        send(16'h2200); step(10);
        send(16'hA100); idle(60);
        send(16'h2200); step(5);

        ph = "R6 kick keeps alive";
        for (int i = 0; i < 3; i++) begin send(16'h0123); step(WD - 50); end

        ph = "R6 R7 watchdog expiry";
        send(16'h0456);
        hi = 0;
        for (int k = 0; k < WD + 40; k++) begin
            @(negedge clk);
            if (rx_rst) hi++;
            step(0);
        end
        chk("R7 rx_rst width", hi, HOLD);

        ph = "R7 ignored during reset";
        step(WD - 45);
        for (int k = 0; k < 40 && !rx_rst; k++) step(1);
        send(16'h9044); send(16'h0999); send(16'h2100);
        prq_valid = 1'b1; prq_num = 12'h0EE; step(3); prq_valid = 1'b0;
        step(HOLD);
        chk("R7 pfw_valid after reset", pfw_valid, 0);
        chk("R7 rly_valid after reset", rly_valid, 0);
        send(16'h0321); step(3);
        chk("R6 timeout events", wd_seen, m_wd_total);
        finish_run();
    end
endmodule